// File: doc/BRIEF.md
# Bit-Serial Arbitration Node

This block is the device-side agent of a shared interrupt arbitration scheme. Each device that can request attention carries one node. The node holds a fixed channel number and a local pending request, which is either an interrupt request or a DMA request. While the request is pending, the node drives the shared request line. It also drives the shared DMA line for a DMA-type request. Every node and the controller share one clock.

The controller starts a round by raising its sync line. The round then has one type step followed by one step per channel bit, taken most significant first. The controller names each bit with a bit-select index.

On every step each contending node sends one bit on the shared arbitration line. A logic 1 is dominant on that line, so the resolved value is the OR of all drives. On the type step a node sends 1 for an interrupt request and 0 for a DMA request. On each address step it sends the inverse of the selected channel bit. A node that sends 0 while the line resolves to 1 has lost. It drives 0 for the rest of the round and keeps its request for a later round.

The result is that interrupt requests beat DMA requests, and within one type the lowest channel number wins. The node still contending after the last bit raises its acknowledge for one cycle. It drops its request on the next clock. The open-drain line resolution lies outside the block: each output is a plain drive enable, and the resolved line comes back in as an input.

Top module: `arb_node`

## Requirements
- R1: After reset, irq_o, dma_o, ida_o and ack_o are all 0 and no request is pending.
- R2: A req_i pulse with no request pending makes irq_o 1 from the next cycle on. dma_o is 1 from the next cycle on only if req_dma_i was 1 with that pulse (1 = DMA type, 0 = interrupt type).
- R3: A req_i pulse while a request is already pending has no effect. In particular, the stored type seen on dma_o does not change.
- R4: ida_o is 0 whenever sync_i is 0. Only a node that has a request pending in the first cycle of sync_i (sync_i 1 after a cycle with sync_i 0) takes part in that round. A request that arrives later waits for the next round.
- R5: In the first cycle of a round, a contending node drives ida_o = 1 for an interrupt-type request and ida_o = 0 for a DMA-type request.
- R6: In each later cycle of the round, a contending node drives ida_o = NOT chan_i[ADDR_W-1-bit_sel_i]. So bit_sel_i = 0 selects the MSB and bit_sel_i = ADDR_W-1 selects the LSB.
- R7: A contending node that drives ida_o = 0 in a cycle where ida_bus_i = 1 has lost. It drives ida_o = 0 for every remaining cycle of that round.
- R8: A node still contending after the cycle with bit_sel_i = ADDR_W-1 drives ack_o = 1 for exactly the next cycle. No other node raises ack_o.
- R9: On the clock edge that ends the ack_o cycle, the node clears its request. irq_o and dma_o read 0 from the following cycle, unless req_i is 1 in the ack_o cycle, in which case that request is taken.
- R10: A node that loses a round keeps its request and type pending and takes part in the next round.
- R11: With the OR-resolved line, an interrupt-type node beats every DMA-type node whatever the channel numbers. Among nodes of the same type, the lowest channel number wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_i | input | ADDR_W | Channel number of this device |
| req_i | input | 1 | Single-cycle pulse that raises a request |
| req_dma_i | input | 1 | Type of the request given with req_i: 1 = DMA, 0 = interrupt |
| sync_i | input | 1 | Round active, driven by the controller |
| bit_sel_i | input | $clog2(ADDR_W) | Index of the channel bit for the current step, 0 = MSB |
| ida_bus_i | input | 1 | Resolved arbitration line (OR of all drives) |
| irq_o | output | 1 | Drive enable for the shared request line |
| dma_o | output | 1 | Drive enable for the shared DMA line |
| ida_o | output | 1 | Drive enable for the arbitration line |
| ack_o | output | 1 | Node has won the round |

## Verification
ida_o is combinational. It is due in the same cycle as the sync_i and bit_sel_i values that select it, so the bench reads every node's ida_o one time unit after it changes those inputs at the falling edge. irq_o and dma_o follow a req_i pulse by one rising edge, and ack_o follows the LSB step by one rising edge. The bench therefore checks these at the falling edge after that rising edge. The release of irq_o is checked one falling edge later still. A reference model of the OR-resolved line tracks which nodes should still be contending at each step. Every node's drive is compared against that model, so a loser that keeps driving is caught even when the OR of all drives hides it.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    REQ_IRQ = 1'b0,
    REQ_DMA = 1'b1
  } req_kind_e;
endpackage

// File: rtl/arb_req_reg.sv
module arb_req_reg
  import arb_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_i,
  input  req_kind_e kind_i,
  input  logic      clr_i,
  output logic      pend_o,
  output req_kind_e kind_o
);
  logic      pend_q;
  req_kind_e kind_q;

  // a new request on the clear cycle is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      kind_q <= REQ_IRQ;
    end else if (req_i && (!pend_q || clr_i)) begin
      pend_q <= 1'b1;
      kind_q <= kind_i;
    end else if (clr_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign kind_o = kind_q;

  p_type_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> (pend_q && $stable(kind_q)));

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !req_i) |=> !pend_q);
endmodule

// File: rtl/arb_bit_pick.sv
module arb_bit_pick #(
  parameter int ADDR_W = 8,
  localparam int IDX_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic [ADDR_W-1:0] chan_i,
  input  logic [IDX_W-1:0]  sel_i,
  output logic              bit_o
);
  logic [ADDR_W-1:0] msb_first;

  // index 0 picks the MSB
  for (genvar g = 0; g < ADDR_W; g++) begin : g_rev
    assign msb_first[g] = chan_i[ADDR_W-1-g];
  end

  if (ADDR_W == (1 << IDX_W)) begin : g_full
    assign bit_o = msb_first[sel_i];
  end else begin : g_guard
    always_comb begin
      bit_o = 1'b0;
      if (int'(sel_i) < ADDR_W) bit_o = msb_first[sel_i];
    end
  end
endmodule

// File: rtl/arb_contend.sv
module arb_contend
  import arb_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sync_i,
  input  logic      pend_i,
  input  req_kind_e kind_i,
  input  logic      addr_bit_i,
  input  logic      last_i,
  input  logic      ida_bus_i,
  output logic      ida_o,
  output logic      ack_o
);
  logic sync_q, cont_q, ack_q;
  logic first, cont_now, present, lose, win_last;

  assign first    = sync_i && !sync_q;
  assign cont_now = first ? pend_i : cont_q;
  // type step: interrupt presents the dominant value
  assign present  = first ? (kind_i == REQ_IRQ) : !addr_bit_i;
  assign ida_o    = sync_i && cont_now && present;
  assign lose     = sync_i && cont_now && !present && ida_bus_i;
  assign win_last = sync_i && !first && last_i && cont_now && !lose;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      cont_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      sync_q <= sync_i;
      cont_q <= sync_i && cont_now && !lose && !win_last;
      ack_q  <= win_last;
    end
  end

  assign ack_o = ack_q;

  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |-> !ida_o);

  p_lost_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && lose) |=> !ida_o);

  p_ack_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  p_ack_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> pend_i);
endmodule

// File: rtl/arb_node.sv
module arb_node
  import arb_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int IDX_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] chan_i,
  input  logic              req_i,
  input  logic              req_dma_i,
  input  logic              sync_i,
  input  logic [IDX_W-1:0]  bit_sel_i,
  input  logic              ida_bus_i,
  output logic              irq_o,
  output logic              dma_o,
  output logic              ida_o,
  output logic              ack_o
);
  localparam logic [IDX_W-1:0] LAST_SEL = IDX_W'(ADDR_W - 1);

  logic      pend, addr_bit, ack;
  req_kind_e kind;

  arb_req_reg i_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .kind_i (req_dma_i ? REQ_DMA : REQ_IRQ),
    .clr_i  (ack),
    .pend_o (pend),
    .kind_o (kind)
  );

  arb_bit_pick #(.ADDR_W(ADDR_W)) i_pick (
    .chan_i (chan_i),
    .sel_i  (bit_sel_i),
    .bit_o  (addr_bit)
  );

  arb_contend i_cont (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .pend_i     (pend),
    .kind_i     (kind),
    .addr_bit_i (addr_bit),
    .last_i     (bit_sel_i == LAST_SEL),
    .ida_bus_i  (ida_bus_i),
    .ida_o      (ida_o),
    .ack_o      (ack)
  );

  assign irq_o = pend;
  assign dma_o = pend && (kind == REQ_DMA);
  assign ack_o = ack;

  p_req_raise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !irq_o) |=> irq_o);

  p_ack_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !req_i) |=> (!irq_o && !dma_o));
endmodule

// File: tb/test_arb_node.sv
module test_arb_node;
  localparam int N = 4;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] chan [N];
  logic [N-1:0]  req, rdma, irq, dma, ida, ack;
  logic          sync;
  logic [2:0]    bsel;
  logic          ida_bus;

  assign ida_bus = |ida;

  for (genvar n = 0; n < N; n++) begin : g_node
    arb_node #(.ADDR_W(AW)) i_arb_node (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .chan_i    (chan[n]),
      .req_i     (req[n]),
      .req_dma_i (rdma[n]),
      .sync_i    (sync),
      .bit_sel_i (bsel),
      .ida_bus_i (ida_bus),
      .irq_o     (irq[n]),
      .dma_o     (dma[n]),
      .ida_o     (ida[n]),
      .ack_o     (ack[n])
    );
  end

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [N-1:0] m_pend = '0, m_dma = '0, m_cont = '0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // pulse requests on the nodes in mask; model takes them only if idle (R3)
  task automatic raise(input logic [N-1:0] mask, input logic [N-1:0] dmask);
    @(negedge clk);
    req = mask; rdma = dmask;
    @(negedge clk);
    req = '0; rdma = '0;
    for (int n = 0; n < N; n++)
      if (mask[n] && !m_pend[n]) begin m_pend[n] = 1'b1; m_dma[n] = dmask[n]; end
    #1;
    chk("R2 R3 irq_o", 32'(irq), 32'(m_pend));
    chk("R2 R3 dma_o", 32'(dma), 32'(m_pend & m_dma));
  endtask

  task automatic step_check(input logic [N-1:0] pres, input string r);
    logic [N-1:0] drv, lose;
    drv  = m_cont & pres;
    chk(r, 32'(ida), 32'(drv));
    lose = m_cont & ~pres & {N{|drv}};
    m_cont = m_cont & ~lose;
  endtask

  task automatic run_round(input logic [N-1:0] late);
    logic [N-1:0] pres, win;
    @(negedge clk);
    sync = 1'b1; bsel = '0;
    m_cont = m_pend;
    #1 step_check(~m_dma, "R5 R11 type step ida_o");
    for (int b = 0; b < AW; b++) begin
      @(negedge clk);
      req = '0;
      bsel = 3'(b);
      if (b == 3) begin req = late; rdma = '0; end  // R4 late request
      for (int n = 0; n < N; n++) pres[n] = !chan[n][AW-1-b];
      #1 step_check(pres, "R6 R7 addr step ida_o");
    end
    for (int n = 0; n < N; n++)
      if (late[n] && !m_pend[n]) begin m_pend[n] = 1'b1; m_dma[n] = 1'b0; end
    win = m_cont;
    @(negedge clk);
    sync = 1'b0; req = '0;
    #1;
    chk("R8 ack_o after LSB", 32'(ack), 32'(win));
    chk("R4 ida_o idle", 32'(ida), 32'h0);
    chk("R9 irq_o held in ack cycle", 32'(irq), 32'(m_pend));
    @(negedge clk);
    #1;
    m_pend = m_pend & ~win;
    chk("R8 ack_o one cycle", 32'(ack), 32'h0);
    chk("R9 R10 irq_o after ack", 32'(irq), 32'(m_pend));
    chk("R9 R10 dma_o after ack", 32'(dma), 32'(m_pend & m_dma));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] m, d;
    void'($urandom(32'd1234));
    req = '0; rdma = '0; sync = 1'b0; bsel = '0;
    for (int n = 0; n < N; n++) chan[n] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 irq_o reset", 32'(irq), 0);
    chk("R1 dma_o reset", 32'(dma), 0);
    chk("R1 ida_o reset", 32'(ida), 0);
    chk("R1 ack_o reset", 32'(ack), 0);
    rst_n = 1'b1;

    // directed: IRQ over DMA, lowest channel wins
    chan[0] = 8'h10; chan[1] = 8'h05; chan[2] = 8'h80; chan[3] = 8'h01;
    raise(4'b0111, 4'b0010);
    raise(4'b0010, 4'b0000);  // R3: type of node 1 must stay DMA
    #1 chk("R4 no drive before sync", 32'(ida), 0);
    run_round(4'b1000);       // node0 wins; node3 arrives late (R4)
    run_round(4'b0000);       // node2 (IRQ) beats node1 (DMA) and node3 (IRQ 0x01)? node3 lower: wins
    run_round(4'b0000);
    run_round(4'b0000);       // R11 DMA node last
    run_round(4'b0000);       // empty round

    // request on the ack cycle is taken (R9)
    raise(4'b0001, 4'b0000);
    @(negedge clk);
    sync = 1'b1; bsel = '0;
    for (int b = 0; b < AW; b++) begin @(negedge clk); bsel = 3'(b); end
    @(negedge clk);
    sync = 1'b0; req = 4'b0001; rdma = 4'b0001;
    #1 chk("R8 ack_o lone node", 32'(ack), 32'h1);
    @(negedge clk);
    req = '0; rdma = '0;
    #1;
    chk("R9 req on ack cycle irq_o", 32'(irq), 32'h1);
    chk("R9 req on ack cycle dma_o", 32'(dma), 32'h1);
    m_pend = 4'b0001; m_dma = 4'b0001;

    // random
    for (int k = 0; k < 60; k++) begin
      for (int n = 0; n < N; n++) chan[n] = 8'($urandom);
      if (k % 7 == 0) chan[1] = chan[0];  // tie case
      m = 4'($urandom); d = 4'($urandom);
      raise(m, d);
      run_round(4'($urandom) & 4'b0101);
    end
    for (int k = 0; k < 6; k++) run_round(4'b0000);
    chk("R10 all requests served", 32'(irq), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule